// File: doc/BRIEF.md
# Bidirectional inter-processor mailbox FIFO

This block joins two processors, called side A and side B, through a pair of word queues. Each queue is 16 entries deep and 32 bits wide, and each one carries data in a single direction. Each side has three things: a 16-bit control/status register, a write-only send port that pushes into its outgoing queue, and a read-only receive port that takes data from its incoming queue. The receive bits of each register always show the same queue state as the send bits of the other side's register.

Reads from an empty queue do not return undefined data. They return the last word that side read and set an error flag. A read made while the reader's enable bit is clear only peeks at the head word and leaves the queue unchanged. Each side has two interrupt outputs. Each one is a one-cycle pulse that fires only on a transition: one when a queue goes from empty to holding data, the other when a pop drains a queue.

Register bits (side-local): 0 send empty, 1 send full, 2 send-empty interrupt enable, 3 send clear (write 1, reads 0), 8 receive empty, 9 receive full, 10 receive-not-empty interrupt enable, 14 error, 15 queue enable.

Top module: `ipc_fifo_bridge`

## Requirements
- R1: After reset, both control registers read 0x0101, both receive data outputs read 0, and all interrupt outputs are low.
- R2: A control write loads only bits 2, 10 and 15. Writing 1 to bit 14 clears the error flag and writing 0 leaves it unchanged. Bits 0, 1, 8 and 9 ignore writes, and bit 3 always reads 0.
- R3: A send-port write is ignored while the sender's bit 15 is clear.
- R4: Words leave a queue in the order they were written. The sender's bits 0 and 1 and the receiver's bits 8 and 9 come from the same count: full at 16 entries, empty at 0.
- R5: A push into a full queue is dropped and sets the sender's bit 14.
- R6: With the reader's bit 15 set, a receive strobe pops the head word. The word appears on the receive data output one cycle later.
- R7: With the reader's bit 15 clear, a receive strobe returns the head word without removing it.
- R8: A receive strobe on an empty queue sets the reader's bit 14 and returns the last word that side read. If that side has read nothing since reset, it returns 0.
- R9: The receiver's receive-not-empty interrupt pulses for one cycle, in the cycle after a push that makes its queue non-empty, but only if the receiver's bit 10 is set.
- R10: The sender's send-empty interrupt pulses for one cycle after a pop that drains its queue, but only if the sender's bit 2 is set. A clear never raises it.
- R11: Writing 1 to bit 3 empties the writer's outgoing queue. A push or pop on that queue in the same cycle is discarded.
- R12: A push and a pop on the same non-full queue in the same cycle are both performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_ctrl_we_i | input | 1 | Side A control register write strobe |
| a_ctrl_wdata_i | input | 16 | Side A control write data |
| a_ctrl_rdata_o | output | 16 | Side A control/status read value |
| a_send_we_i | input | 1 | Side A send-port write strobe |
| a_send_data_i | input | 32 | Side A word to send |
| a_recv_re_i | input | 1 | Side A receive-port read strobe |
| a_recv_data_o | output | 32 | Side A received word, valid the cycle after the strobe |
| a_irq_send_empty_o | output | 1 | Side A outgoing queue drained pulse |
| a_irq_recv_ne_o | output | 1 | Side A incoming queue became non-empty pulse |
| b_ctrl_we_i | input | 1 | Side B control register write strobe |
| b_ctrl_wdata_i | input | 16 | Side B control write data |
| b_ctrl_rdata_o | output | 16 | Side B control/status read value |
| b_send_we_i | input | 1 | Side B send-port write strobe |
| b_send_data_i | input | 32 | Side B word to send |
| b_recv_re_i | input | 1 | Side B receive-port read strobe |
| b_recv_data_o | output | 32 | Side B received word, valid the cycle after the strobe |
| b_irq_send_empty_o | output | 1 | Side B outgoing queue drained pulse |
| b_irq_recv_ne_o | output | 1 | Side B incoming queue became non-empty pulse |

## Verification
The hardest state to reach is a queue at its exact capacity at the moment another push arrives. The bench fills the A-to-B queue with 16 numbered words and checks the full flags on both sides. It then pushes a 17th word, expects the sender's error flag, and drains all 16 entries to confirm the extra word never entered. The collision cases are driven in a single cycle by raising two strobes at once: clear together with push, and push together with pop. The bench then checks the count through the empty flags.

// File: rtl/ipc_pkg.sv
package ipc_pkg;
  localparam int CTRL_W     = 16;
  localparam int B_TX_EMPTY = 0;
  localparam int B_TX_FULL  = 1;
  localparam int B_TX_IE    = 2;
  localparam int B_TX_CLR   = 3;
  localparam int B_RX_EMPTY = 8;
  localparam int B_RX_FULL  = 9;
  localparam int B_RX_IE    = 10;
  localparam int B_ERR      = 14;
  localparam int B_EN       = 15;
endpackage

// File: rtl/ipc_fifo.sv
module ipc_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic              pop_en_i,
  input  logic              ie_ne_i,
  input  logic              ie_empty_i,
  output logic              empty_o,
  output logic              full_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              push_err_o,
  output logic              rd_err_o,
  output logic              irq_ne_o,
  output logic              irq_empty_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [DATA_W-1:0] rdata_q;
  logic              irq_ne_q, irq_empty_q;
  logic              push_ok, pop_ok;

  assign empty_o    = (cnt_q == '0);
  assign full_o     = (cnt_q == CW'(DEPTH));
  assign push_ok    = push_i & ~full_o & ~clr_i;
  assign pop_ok     = rd_i & pop_en_i & ~empty_o & ~clr_i;
  assign push_err_o = push_i & full_o;
  assign rd_err_o   = rd_i & empty_o;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) cnt_d = '0;
    else cnt_d = cnt_q + CW'(push_ok) - CW'(pop_ok);
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q    <= '0;
      rd_ptr_q    <= '0;
      cnt_q       <= '0;
      rdata_q     <= '0;
      irq_ne_q    <= 1'b0;
      irq_empty_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (clr_i) begin
        wr_ptr_q <= '0;
        rd_ptr_q <= '0;
      end else begin
        if (push_ok) wr_ptr_q <= wr_ptr_q + 1'b1;
        if (pop_ok)  rd_ptr_q <= rd_ptr_q + 1'b1;
      end
      // holding rdata_q on an empty read yields the last word read
      if (rd_i && !empty_o) rdata_q <= mem[rd_ptr_q];
      irq_ne_q    <= ie_ne_i & empty_o & (cnt_d != '0);
      irq_empty_q <= ie_empty_i & pop_ok & (cnt_d == '0);
    end
  end

  assign rdata_o     = rdata_q;
  assign irq_ne_o    = irq_ne_q;
  assign irq_empty_o = irq_empty_q;
endmodule

// File: rtl/ipc_ctrl.sv
module ipc_ctrl
  import ipc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              err_set_i,
  input  logic              tx_empty_i,
  input  logic              tx_full_i,
  input  logic              rx_empty_i,
  input  logic              rx_full_i,
  output logic [CTRL_W-1:0] rdata_o,
  output logic              en_o,
  output logic              tx_ie_o,
  output logic              rx_ie_o,
  output logic              tx_clr_o
);
  logic en_q, err_q, tx_ie_q, rx_ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      err_q   <= 1'b0;
      tx_ie_q <= 1'b0;
      rx_ie_q <= 1'b0;
    end else begin
      if (we_i) begin
        en_q    <= wdata_i[B_EN];
        tx_ie_q <= wdata_i[B_TX_IE];
        rx_ie_q <= wdata_i[B_RX_IE];
      end
      // a new fault wins over a same-cycle acknowledge
      if (err_set_i) err_q <= 1'b1;
      else if (we_i && wdata_i[B_ERR]) err_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o             = '0;
    rdata_o[B_TX_EMPTY] = tx_empty_i;
    rdata_o[B_TX_FULL]  = tx_full_i;
    rdata_o[B_TX_IE]    = tx_ie_q;
    rdata_o[B_RX_EMPTY] = rx_empty_i;
    rdata_o[B_RX_FULL]  = rx_full_i;
    rdata_o[B_RX_IE]    = rx_ie_q;
    rdata_o[B_ERR]      = err_q;
    rdata_o[B_EN]       = en_q;
  end

  assign en_o     = en_q;
  assign tx_ie_o  = tx_ie_q;
  assign rx_ie_o  = rx_ie_q;
  assign tx_clr_o = we_i & wdata_i[B_TX_CLR];
endmodule

// File: rtl/ipc_fifo_bridge.sv
module ipc_fifo_bridge
  import ipc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              a_ctrl_we_i,
  input  logic [CTRL_W-1:0] a_ctrl_wdata_i,
  output logic [CTRL_W-1:0] a_ctrl_rdata_o,
  input  logic              a_send_we_i,
  input  logic [DATA_W-1:0] a_send_data_i,
  input  logic              a_recv_re_i,
  output logic [DATA_W-1:0] a_recv_data_o,
  output logic              a_irq_send_empty_o,
  output logic              a_irq_recv_ne_o,
  input  logic              b_ctrl_we_i,
  input  logic [CTRL_W-1:0] b_ctrl_wdata_i,
  output logic [CTRL_W-1:0] b_ctrl_rdata_o,
  input  logic              b_send_we_i,
  input  logic [DATA_W-1:0] b_send_data_i,
  input  logic              b_recv_re_i,
  output logic [DATA_W-1:0] b_recv_data_o,
  output logic              b_irq_send_empty_o,
  output logic              b_irq_recv_ne_o
);
  localparam int NSIDE = 2;

  // index 0 = side A, 1 = side B; queue g carries side g -> side 1-g
  logic [NSIDE-1:0]  ctrl_we, send_we, recv_re;
  logic [CTRL_W-1:0] ctrl_wdata [NSIDE];
  logic [CTRL_W-1:0] ctrl_rdata [NSIDE];
  logic [DATA_W-1:0] send_data  [NSIDE];
  logic [DATA_W-1:0] recv_data  [NSIDE];
  logic [NSIDE-1:0]  en, tx_ie, rx_ie, tx_clr;
  logic [NSIDE-1:0]  q_empty, q_full, push_err, rd_err;
  logic [NSIDE-1:0]  irq_se, irq_rne;

  assign ctrl_we      = {b_ctrl_we_i, a_ctrl_we_i};
  assign send_we      = {b_send_we_i, a_send_we_i};
  assign recv_re      = {b_recv_re_i, a_recv_re_i};
  assign ctrl_wdata[0] = a_ctrl_wdata_i;
  assign ctrl_wdata[1] = b_ctrl_wdata_i;
  assign send_data[0]  = a_send_data_i;
  assign send_data[1]  = b_send_data_i;

  for (genvar g = 0; g < NSIDE; g++) begin : g_side
    localparam int R = NSIDE - 1 - g;

    ipc_ctrl i_ctrl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (ctrl_we[g]),
      .wdata_i   (ctrl_wdata[g]),
      .err_set_i (push_err[g] | rd_err[R]),
      .tx_empty_i(q_empty[g]),
      .tx_full_i (q_full[g]),
      .rx_empty_i(q_empty[R]),
      .rx_full_i (q_full[R]),
      .rdata_o   (ctrl_rdata[g]),
      .en_o      (en[g]),
      .tx_ie_o   (tx_ie[g]),
      .rx_ie_o   (rx_ie[g]),
      .tx_clr_o  (tx_clr[g])
    );

    ipc_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_fifo (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (tx_clr[g]),
      .push_i     (send_we[g] & en[g]),
      .wdata_i    (send_data[g]),
      .rd_i       (recv_re[R]),
      .pop_en_i   (en[R]),
      .ie_ne_i    (rx_ie[R]),
      .ie_empty_i (tx_ie[g]),
      .empty_o    (q_empty[g]),
      .full_o     (q_full[g]),
      .rdata_o    (recv_data[R]),
      .push_err_o (push_err[g]),
      .rd_err_o   (rd_err[g]),
      .irq_ne_o   (irq_rne[R]),
      .irq_empty_o(irq_se[g])
    );
  end

  assign a_ctrl_rdata_o     = ctrl_rdata[0];
  assign b_ctrl_rdata_o     = ctrl_rdata[1];
  assign a_recv_data_o      = recv_data[0];
  assign b_recv_data_o      = recv_data[1];
  assign a_irq_send_empty_o = irq_se[0];
  assign b_irq_send_empty_o = irq_se[1];
  assign a_irq_recv_ne_o    = irq_rne[0];
  assign b_irq_recv_ne_o    = irq_rne[1];
endmodule

// File: rtl/ipc_fifo_bridge_chk.sv
module ipc_fifo_bridge_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              a_ctrl_we_i,
  input logic [15:0]       a_ctrl_wdata_i,
  input logic [15:0]       a_ctrl_rdata_o,
  input logic              a_send_we_i,
  input logic              a_irq_send_empty_o,
  input logic [15:0]       b_ctrl_rdata_o,
  input logic              b_recv_re_i,
  input logic [DATA_W-1:0] b_recv_data_o,
  input logic              b_irq_recv_ne_o
);
  a_r4_not_full_and_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(a_ctrl_rdata_o[0] && a_ctrl_rdata_o[1]));

  a_r3_disabled_push_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_send_we_i && !a_ctrl_rdata_o[15] && !b_recv_re_i && !a_ctrl_we_i)
    |=> $stable(b_ctrl_rdata_o[9:8]));

  a_r5_full_push_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_send_we_i && a_ctrl_rdata_o[15] && a_ctrl_rdata_o[1]) |=> a_ctrl_rdata_o[14]);

  a_r8_empty_read_error: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_recv_re_i && b_ctrl_rdata_o[8]) |=> b_ctrl_rdata_o[14]);

  a_r8_empty_read_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (b_recv_re_i && b_ctrl_rdata_o[8]) |=> $stable(b_recv_data_o));

  a_r9_ne_irq_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_irq_recv_ne_o |-> ($past(b_ctrl_rdata_o[8]) && !b_ctrl_rdata_o[8] && $past(b_ctrl_rdata_o[10])));

  a_r10_empty_irq_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_irq_send_empty_o |-> (!$past(a_ctrl_rdata_o[0]) && a_ctrl_rdata_o[0] && $past(a_ctrl_rdata_o[2])));

  a_r9_ne_irq_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    b_irq_recv_ne_o |=> !b_irq_recv_ne_o);
endmodule

bind ipc_fifo_bridge ipc_fifo_bridge_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i             (clk_i),
  .rst_ni            (rst_ni),
  .a_ctrl_we_i       (a_ctrl_we_i),
  .a_ctrl_wdata_i    (a_ctrl_wdata_i),
  .a_ctrl_rdata_o    (a_ctrl_rdata_o),
  .a_send_we_i       (a_send_we_i),
  .a_irq_send_empty_o(a_irq_send_empty_o),
  .b_ctrl_rdata_o    (b_ctrl_rdata_o),
  .b_recv_re_i       (b_recv_re_i),
  .b_recv_data_o     (b_recv_data_o),
  .b_irq_recv_ne_o   (b_irq_recv_ne_o)
);

// File: tb/test_ipc_fifo_bridge.sv
`timescale 1ns/1ps
module test_ipc_fifo_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_ctrl_we = 1'b0, b_ctrl_we = 1'b0;
  logic [15:0] a_ctrl_wdata = '0, b_ctrl_wdata = '0;
  logic [15:0] a_ctrl_rdata, b_ctrl_rdata;
  logic        a_send_we = 1'b0, b_send_we = 1'b0;
  logic [31:0] a_send_data = '0, b_send_data = '0;
  logic        a_recv_re = 1'b0, b_recv_re = 1'b0;
  logic [31:0] a_recv_data, b_recv_data;
  logic        a_irq_se, a_irq_rne, b_irq_se, b_irq_rne;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ipc_fifo_bridge i_ipc_fifo_bridge (
    .clk_i(clk), .rst_ni(rst_n),
    .a_ctrl_we_i(a_ctrl_we), .a_ctrl_wdata_i(a_ctrl_wdata), .a_ctrl_rdata_o(a_ctrl_rdata),
    .a_send_we_i(a_send_we), .a_send_data_i(a_send_data),
    .a_recv_re_i(a_recv_re), .a_recv_data_o(a_recv_data),
    .a_irq_send_empty_o(a_irq_se), .a_irq_recv_ne_o(a_irq_rne),
    .b_ctrl_we_i(b_ctrl_we), .b_ctrl_wdata_i(b_ctrl_wdata), .b_ctrl_rdata_o(b_ctrl_rdata),
    .b_send_we_i(b_send_we), .b_send_data_i(b_send_data),
    .b_recv_re_i(b_recv_re), .b_recv_data_o(b_recv_data),
    .b_irq_send_empty_o(b_irq_se), .b_irq_recv_ne_o(b_irq_rne)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic ctrl_wr(input bit side_b, input logic [15:0] v);
    if (side_b) begin b_ctrl_we = 1'b1; b_ctrl_wdata = v; end
    else begin a_ctrl_we = 1'b1; a_ctrl_wdata = v; end
    @(negedge clk);
    a_ctrl_we = 1'b0; b_ctrl_we = 1'b0;
  endtask

  task automatic push_a(input logic [31:0] v);
    a_send_we = 1'b1; a_send_data = v;
    @(negedge clk);
    a_send_we = 1'b0;
  endtask

  task automatic rd(input bit side_b, output logic [31:0] d);
    if (side_b) b_recv_re = 1'b1; else a_recv_re = 1'b1;
    @(negedge clk);
    a_recv_re = 1'b0; b_recv_re = 1'b0;
    d = side_b ? b_recv_data : a_recv_data;
  endtask

  task automatic t_reset();
    chk("R1 a ctrl", 32'(a_ctrl_rdata), 32'h0101);
    chk("R1 b ctrl", 32'(b_ctrl_rdata), 32'h0101);
    chk("R1 rx data", a_recv_data | b_recv_data, 32'h0);
    chk("R1 irqs", 32'({a_irq_se, a_irq_rne, b_irq_se, b_irq_rne}), 32'h0);
  endtask

  task automatic t_ctrl();
    ctrl_wr(1'b0, 16'hFFFF);
    chk("R2 write all ones", 32'(a_ctrl_rdata), 32'h8505);
    ctrl_wr(1'b0, 16'h0000);
    chk("R2 write zeros", 32'(a_ctrl_rdata), 32'h0101);
    ctrl_wr(1'b0, 16'h8000);
    ctrl_wr(1'b1, 16'h8000);
    chk("R2 enable", 32'(b_ctrl_rdata), 32'h8101);
  endtask

  task automatic t_first_empty_read();
    logic [31:0] d;
    rd(1'b0, d);
    chk("R8 first empty read data", d, 32'h0);
    chk("R8 reader error", 32'(a_ctrl_rdata[14]), 32'h1);
    ctrl_wr(1'b0, 16'h0000);
    chk("R2 write 0 keeps error", 32'(a_ctrl_rdata[14]), 32'h1);
    ctrl_wr(1'b0, 16'hC000);
    chk("R2 write 1 clears error", 32'(a_ctrl_rdata), 32'h8101);
  endtask

  task automatic t_disabled_push();
    ctrl_wr(1'b0, 16'h0000);
    push_a(32'hDEAD);
    chk("R3 push ignored rx empty", 32'(b_ctrl_rdata[8]), 32'h1);
    chk("R3 push ignored tx empty", 32'(a_ctrl_rdata[0]), 32'h1);
    ctrl_wr(1'b0, 16'h8000);
  endtask

  task automatic t_fill_drain();
    logic [31:0] d;
    for (int i = 0; i < 16; i++) begin
      if (i == 15) chk("R4 not full at 15", 32'({a_ctrl_rdata[1], b_ctrl_rdata[9]}), 32'h0);
      push_a(32'h1000 + 32'(i));
    end
    chk("R4 sender flags full", 32'(a_ctrl_rdata[1:0]), 32'h2);
    chk("R4 receiver flags full", 32'(b_ctrl_rdata[9:8]), 32'h2);
    push_a(32'hBAD0);
    chk("R5 overflow error", 32'(a_ctrl_rdata[14]), 32'h1);
    ctrl_wr(1'b0, 16'hC000);
    for (int i = 0; i < 16; i++) begin
      rd(1'b1, d);
      chk("R6 R4 pop order", d, 32'h1000 + 32'(i));
    end
    chk("R4 sender empty after drain", 32'(a_ctrl_rdata[1:0]), 32'h1);
    chk("R5 dropped word absent", 32'(b_ctrl_rdata[8]), 32'h1);
  endtask

  task automatic t_peek();
    logic [31:0] d;
    push_a(32'hAAAA);
    ctrl_wr(1'b1, 16'h0000);
    rd(1'b1, d);
    chk("R7 peek data", d, 32'hAAAA);
    rd(1'b1, d);
    chk("R7 peek again", d, 32'hAAAA);
    chk("R7 still not empty", 32'(b_ctrl_rdata[8]), 32'h0);
    ctrl_wr(1'b1, 16'h8000);
    rd(1'b1, d);
    chk("R6 pop after enable", d, 32'hAAAA);
    chk("R6 empty after pop", 32'(b_ctrl_rdata[8]), 32'h1);
    rd(1'b1, d);
    chk("R8 empty read returns last", d, 32'hAAAA);
    chk("R8 reader error b", 32'(b_ctrl_rdata[14]), 32'h1);
    ctrl_wr(1'b1, 16'hC000);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    ctrl_wr(1'b1, 16'h8400);
    push_a(32'h11);
    chk("R9 irq on empty->ne", 32'(b_irq_rne), 32'h1);
    @(negedge clk);
    chk("R9 irq one cycle", 32'(b_irq_rne), 32'h0);
    push_a(32'h22);
    chk("R9 no irq when already ne", 32'(b_irq_rne), 32'h0);
    ctrl_wr(1'b0, 16'h8004);
    rd(1'b1, d);
    chk("R10 no irq while ne", 32'(a_irq_se), 32'h0);
    rd(1'b1, d);
    chk("R10 irq on drain", 32'(a_irq_se), 32'h1);
    chk("R10 drained data", d, 32'h22);
    ctrl_wr(1'b1, 16'h8000);
    push_a(32'h33);
    chk("R9 masked irq", 32'(b_irq_rne), 32'h0);
  endtask

  task automatic t_clear();
    push_a(32'h44);
    push_a(32'h55);
    ctrl_wr(1'b0, 16'h800C);
    chk("R11 sender empty", 32'(a_ctrl_rdata[1:0]), 32'h1);
    chk("R11 receiver empty", 32'(b_ctrl_rdata[9:8]), 32'h1);
    chk("R10 no irq on clear", 32'(a_irq_se), 32'h0);
    chk("R11 clear bit reads 0", 32'(a_ctrl_rdata[3]), 32'h0);
    a_send_we = 1'b1; a_send_data = 32'h66;
    a_ctrl_we = 1'b1; a_ctrl_wdata = 16'h8008;
    @(negedge clk);
    a_send_we = 1'b0; a_ctrl_we = 1'b0;
    chk("R11 clear beats push", 32'(b_ctrl_rdata[8]), 32'h1);
  endtask

  task automatic t_simul();
    logic [31:0] d;
    push_a(32'h51);
    a_send_we = 1'b1; a_send_data = 32'h52;
    b_recv_re = 1'b1;
    @(negedge clk);
    a_send_we = 1'b0; b_recv_re = 1'b0;
    chk("R12 popped word", b_recv_data, 32'h51);
    chk("R12 one left", 32'(b_ctrl_rdata[8]), 32'h0);
    rd(1'b1, d);
    chk("R12 pushed word", d, 32'h52);
    chk("R12 empty", 32'(b_ctrl_rdata[8]), 32'h1);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_first_empty_read();
    t_disabled_push();
    t_fill_drain();
    t_peek();
    t_irq();
    t_clear();
    t_simul();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule